// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block drives the two board lines that power a clock source: a crystal power-up line (`xtal_pu`, high means crystal running) and a PLL power-down line (`pll_pd`, high means PLL held off, so the PLL runs when it is low). It also keeps an output-enable register with one bit for each line. A request carries a two-bit selection (bit 0 crystal, bit 1 PLL) and an on/off flag. The block then steps through a timed sequence that switches the selected parts without disturbing the others.

Power-up first looks at the crystal status input, which is sampled in the cycle the request is accepted. If the crystal is already running, the block skips every line write, so a clock that is already in use is not glitched. Otherwise the crystal is started with the PLL held off and given a settling wait. The PLL is then released and given its own lock wait. Every power-up ends with a one-cycle pulse that clears a write-one-to-clear abort status bit elsewhere in the chip. Power-down writes the lines in one step and has no wait. Both wait lengths are cycle-count parameters.

Top module: `clk_src_pwrseq`

## Requirements
- R1: After synchronous reset, `xtal_pu`, `pll_pd`, `line_oe`, `busy` and `abort_clr` are all 0.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle until the sequence ends. A request presented while `busy` is high is dropped: it is not queued and has no effect on the lines, the enables or the sequence length.
- R3: Each crystal-start step and each power-down step ORs the selection mask into `line_oe` (bit 0 crystal, bit 1 PLL). No enable bit is ever cleared except by reset, and a PLL-only power-up leaves `line_oe` unchanged.
- R4: On a power-up where `xtal_sense` is high at acceptance, no line or enable changes. The sequence lasts one busy cycle, and `abort_clr` pulses in that cycle.
- R5: On a power-up with the crystal selected and `xtal_sense` low, `xtal_pu` is set, and `pll_pd` is set as well if the PLL is selected. Both lines then hold for XTAL_WAIT_CYC+1 cycles before the next step.
- R6: On a power-up with the PLL selected and `xtal_sense` low, `pll_pd` is then cleared. It stays cleared for PLL_WAIT_CYC busy cycles before the abort clear. A full power-up of both parts takes XTAL_WAIT_CYC+PLL_WAIT_CYC+3 busy cycles. A PLL-only power-up takes PLL_WAIT_CYC+2 busy cycles.
- R7: Every power-up, including a skipped one or one with an empty selection, raises `abort_clr` for exactly one cycle, in its last busy cycle. Power-down never raises it.
- R8: On power-down, `xtal_pu` is cleared if the crystal is selected and `pll_pd` is set if the PLL is selected, with the enables ORed in. The sequence lasts one busy cycle, with no wait.
- R9: A line whose part is not selected keeps its value through any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 2 | Selection: bit 0 crystal, bit 1 PLL |
| req_on | input | 1 | 1 = power up, 0 = power down |
| xtal_sense | input | 1 | Crystal running status, synchronous to clk |
| xtal_pu | output | 1 | Crystal power-up line |
| pll_pd | output | 1 | PLL power-down line (low runs the PLL) |
| line_oe | output | 2 | Output enables: bit 0 crystal, bit 1 PLL |
| busy | output | 1 | Sequence in progress |
| abort_clr | output | 1 | One-cycle clear pulse for the abort status bit |

## Verification
The assertions assume that `xtal_sense`, `req_sel` and `req_on` are already synchronous to `clk` and stable around the acceptance edge. They also assume that the wait parameters are at least 1. The bench changes every input on the falling edge only. It lowers `req_valid` one cycle after raising it, and it moves `xtal_sense` in the middle of a sequence only to show that the value taken at acceptance is the one that counts. It runs with short waits, so that each wait window can be counted cycle by cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef struct packed {
        logic pll;
        logic xtal;
    } src_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XTAL_WR,
        ST_XTAL_WAIT,
        ST_PLL_WR,
        ST_PLL_WAIT,
        ST_ABORT_CLR,
        ST_DOWN_WR
    } seq_state_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_XTAL_UP,
        WR_PLL_EN,
        WR_DOWN
    } wr_cmd_t;

    // Crystal start: crystal on, PLL held off if it is part of the request.
    function automatic src_sel_t f_xtal_up(src_sel_t cur, src_sel_t sel);
        src_sel_t r;
        r      = cur;
        r.xtal = 1'b1;
        if (sel.pll) r.pll = 1'b1;
        return r;
    endfunction

    // Release the PLL (its line is a power-down, so low runs it).
    function automatic src_sel_t f_pll_run(src_sel_t cur);
        src_sel_t r;
        r     = cur;
        r.pll = 1'b0;
        return r;
    endfunction

    function automatic src_sel_t f_power_down(src_sel_t cur, src_sel_t sel);
        src_sel_t r;
        r = cur;
        if (sel.xtal) r.xtal = 1'b0;
        if (sel.pll)  r.pll  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5/R6: a load takes effect at the next edge
    a_r5_timer_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R6: the counter never wraps
    a_r6_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  src_sel_t   req_sel,
    input  logic       req_on,
    input  logic       xtal_sense,
    input  logic       tmr_zero,
    output seq_state_t state,
    output src_sel_t   sel_q,
    output wr_cmd_t    cmd,
    output logic       tmr_load,
    output logic       busy,
    output logic       abort_clr
);
    seq_state_t state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (!req_on)          state_d = ST_DOWN_WR;
                else if (xtal_sense)  state_d = ST_ABORT_CLR;
                else if (req_sel.xtal) state_d = ST_XTAL_WR;
                else if (req_sel.pll)  state_d = ST_PLL_WR;
                else                   state_d = ST_ABORT_CLR;
            end
            ST_XTAL_WR:   state_d = ST_XTAL_WAIT;
            ST_XTAL_WAIT: if (tmr_zero) state_d = sel_q.pll ? ST_PLL_WR : ST_ABORT_CLR;
            ST_PLL_WR:    state_d = ST_PLL_WAIT;
            ST_PLL_WAIT:  if (tmr_zero) state_d = ST_ABORT_CLR;
            ST_ABORT_CLR: state_d = ST_IDLE;
            ST_DOWN_WR:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) sel_q <= req_sel;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_XTAL_WR: cmd = WR_XTAL_UP;
            ST_PLL_WR:  cmd = WR_PLL_EN;
            ST_DOWN_WR: cmd = WR_DOWN;
            default:    cmd = WR_NONE;
        endcase
    end

    assign state     = state_q;
    assign tmr_load  = (state_q == ST_XTAL_WR) || (state_q == ST_PLL_WR);
    assign busy      = (state_q != ST_IDLE);
    assign abort_clr = (state_q == ST_ABORT_CLR);

    // R4: a running crystal skips straight to the abort clear
    a_r4_skip_when_running: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req_valid && req_on && xtal_sense) |=> (state_q == ST_ABORT_CLR));

    // R7: the clear is a single-cycle pulse followed by idle
    a_r7_abort_one_cycle: assert property (@(posedge clk) disable iff (rst)
        abort_clr |=> (!abort_clr && !busy));

    // R8: power-down finishes after one step
    a_r8_down_no_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DOWN_WR) |=> (state_q == ST_IDLE));

    // R2: the held selection does not change while busy
    a_r2_sel_stable_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sel_q));
endmodule

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
    import pwrseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    input  src_sel_t sel,
    output src_sel_t lines,
    output src_sel_t oe
);
    src_sel_t lines_q, oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
            oe_q    <= '0;
        end else begin
            unique case (cmd)
                WR_XTAL_UP: begin
                    lines_q <= f_xtal_up(lines_q, sel);
                    oe_q    <= oe_q | sel;
                end
                WR_PLL_EN:  lines_q <= f_pll_run(lines_q);
                WR_DOWN: begin
                    lines_q <= f_power_down(lines_q, sel);
                    oe_q    <= oe_q | sel;
                end
                default: ;
            endcase
        end
    end

    assign lines = lines_q;
    assign oe    = oe_q;

    // R3: enable bits are never cleared outside reset
    a_r3_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(oe_q) & ~oe_q) == '0));

    // R6: the PLL release step leaves the PLL running
    a_r6_pll_released: assert property (@(posedge clk) disable iff (rst)
        (cmd == WR_PLL_EN) |=> !lines_q.pll);

    // R9: with no write command the lines hold
    a_r9_hold_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd == WR_NONE) |=> $stable(lines_q));
endmodule

// File: rtl/clk_src_pwrseq.sv
module clk_src_pwrseq
    import pwrseq_pkg::*;
#(
    parameter int XTAL_WAIT_CYC = 50000,
    parameter int PLL_WAIT_CYC  = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_sel,
    input  logic       req_on,
    input  logic       xtal_sense,
    output logic       xtal_pu,
    output logic       pll_pd,
    output logic [1:0] line_oe,
    output logic       busy,
    output logic       abort_clr
);
    localparam int MAX_WAIT = (XTAL_WAIT_CYC > PLL_WAIT_CYC) ? XTAL_WAIT_CYC : PLL_WAIT_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] XTAL_LOAD = CNT_W'(XTAL_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] PLL_LOAD  = CNT_W'(PLL_WAIT_CYC - 1);

    seq_state_t       state;
    src_sel_t         sel_q;
    wr_cmd_t          cmd;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    src_sel_t         lines;
    src_sel_t         oe;

    pwrseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_sel    (src_sel_t'(req_sel)),
        .req_on     (req_on),
        .xtal_sense (xtal_sense),
        .tmr_zero   (tmr_zero),
        .state      (state),
        .sel_q      (sel_q),
        .cmd        (cmd),
        .tmr_load   (tmr_load),
        .busy       (busy),
        .abort_clr  (abort_clr)
    );

    assign tmr_val = (state == ST_XTAL_WR) ? XTAL_LOAD : PLL_LOAD;

    pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pwrseq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .sel   (sel_q),
        .lines (lines),
        .oe    (oe)
    );

    assign xtal_pu = lines.xtal;
    assign pll_pd  = lines.pll;
    assign line_oe = oe;

    // R2: a request while busy does not restart or end the sequence early
    a_r2_busy_ignores_req: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && state == ST_XTAL_WAIT && !tmr_zero) |=> (state == ST_XTAL_WAIT));

    // R5: during the crystal wait the PLL stays held off when it is selected
    a_r5_pll_held_in_xtal_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XTAL_WAIT && sel_q.pll) |-> (xtal_pu && pll_pd));
endmodule

// File: tb/tb_clk_src_pwrseq.sv
module tb_clk_src_pwrseq;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 4;
    localparam int PW = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_sel;
    logic       req_on;
    logic       xtal_sense;
    logic       xtal_pu, pll_pd, busy, abort_clr;
    logic [1:0] line_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // per-sequence measurements
    int n_busy, n_both_high, n_pll_run, n_abort, abort_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_pwrseq #(.XTAL_WAIT_CYC(XW), .PLL_WAIT_CYC(PW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_on(req_on), .xtal_sense(xtal_sense), .xtal_pu(xtal_pu),
        .pll_pd(pll_pd), .line_oe(line_oe), .busy(busy), .abort_clr(abort_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_lines(input string tag, input int x, input int p, input int oe);
        chk({tag, " xtal_pu"}, int'(xtal_pu), x);
        chk({tag, " pll_pd"}, int'(pll_pd), p);
        chk({tag, " line_oe"}, int'(line_oe), oe);
    endtask

    // Issue one request; optionally inject a second request and a sense change at sample inj_at.
    task automatic run_seq(input logic [1:0] sel, input logic on, input logic sense, input int inj_at);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_on = on; xtal_sense = sense;
        n_busy = 0; n_both_high = 0; n_pll_run = 0; n_abort = 0; abort_last = 0;
        k = 0;
        while (k < 1000) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!busy) break;
            n_busy++;
            if (xtal_pu && pll_pd) n_both_high++;
            if (!pll_pd && !abort_clr && (xtal_pu || !sel[0])) n_pll_run++;
            if (abort_clr) n_abort++;
            abort_last = int'(abort_clr);
            if (k == inj_at) begin
                req_valid = 1'b1; req_sel = 2'b11; req_on = ~on; xtal_sense = ~sense;
            end
            k++;
        end
        req_valid = 1'b0;
        xtal_sense = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_sel = 2'b00; req_on = 1'b0; xtal_sense = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_lines("R1 reset", 0, 0, 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset abort_clr", int'(abort_clr), 0);
    endtask

    task automatic t_down_pll();
        run_seq(2'b10, 1'b0, 1'b0, -1);
        chk_lines("R8 R9 R3 down pll only", 0, 1, 2);
        chk("R8 down busy cycles", n_busy, 1);
        chk("R7 down no abort", n_abort, 0);
    endtask

    task automatic t_up_both();
        run_seq(2'b11, 1'b1, 1'b0, -1);
        chk_lines("R5 R6 R3 up both", 1, 0, 3);
        chk("R5 xtal wait with pll held", n_both_high, XW + 1);
        chk("R6 pll run before clear", n_pll_run, PW);
        chk("R6 total busy", n_busy, XW + PW + 3);
        chk("R7 abort count", n_abort, 1);
        chk("R7 abort in last cycle", abort_last, 1);
    endtask

    task automatic t_skip();
        run_seq(2'b11, 1'b1, 1'b1, -1);
        chk_lines("R4 skip unchanged", 1, 0, 3);
        chk("R4 skip busy", n_busy, 1);
        chk("R4 R7 skip abort", n_abort, 1);
    endtask

    task automatic t_down_xtal();
        run_seq(2'b01, 1'b0, 1'b0, -1);
        chk_lines("R8 R9 down xtal only", 0, 0, 3);
        chk("R8 down xtal busy", n_busy, 1);
    endtask

    task automatic t_up_pll();
        run_seq(2'b10, 1'b1, 1'b0, -1);
        chk_lines("R6 R3 R9 up pll only", 0, 0, 3);
        chk("R6 pll only busy", n_busy, PW + 2);
        chk("R6 pll only run", n_pll_run, PW + 1);
        chk("R7 pll only abort", n_abort, 1);
    endtask

    task automatic t_busy_ignore();
        run_seq(2'b11, 1'b1, 1'b0, 2);
        chk_lines("R2 ignored request", 1, 0, 3);
        chk("R2 busy length kept", n_busy, XW + PW + 3);
        chk("R2 R4 sense taken at accept", n_both_high, XW + 1);
        @(negedge clk);
        chk("R2 not queued", int'(busy), 0);
    endtask

    task automatic t_up_none();
        run_seq(2'b00, 1'b1, 1'b0, -1);
        chk_lines("R7 R9 empty selection", 1, 0, 3);
        chk("R7 empty selection busy", n_busy, 1);
        chk("R7 empty selection abort", n_abort, 1);
    endtask

    initial begin
        t_reset();
        t_down_pll();
        t_up_both();
        t_skip();
        t_down_xtal();
        t_up_pll();
        t_down_xtal();
        t_busy_ignore();
        t_up_none();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule